// File: doc/BRIEF.md
# PTP transmit timestamp inserter

This block sits in a packet transmit path and handles IEEE 1588 timing for outgoing frames. Frames arrive as a stream of 16-byte beats with start and end markers. With each start beat come per-packet controls and a 96-bit time-of-day value taken when the frame entered the path. From that entry time the block forms the exit time. The exit time is the entry time plus a fixed internal latency plus a latency offset that software writes into a register.

In one-step operation the block edits the frame as it passes. At a byte position given per packet, it can replace a 12-byte timestamp field with the exit time. It can instead write back the field plus the exit time, or the exit time minus the field. It can also clear a two-byte TCP checksum at a second per-packet byte position. In two-step operation the frame goes through untouched. The exit time is presented on a side bus, together with a strobe, in the same cycle as the first beat of the frame leaves the block.

The stream has a fixed delay of two cycles. One beat is held back, so a field that crosses a beat boundary can be rewritten in a single pass.

Top module: `ptp_tx_stamper`

## Requirements
- R1: Each input beat appears on the output exactly two clock cycles after it is accepted, with its valid, start and end markers. Byte lane j of a beat is data[8j+7:8j], and lane 0 is the earliest byte on the wire. The beats of one packet arrive on consecutive cycles.
- R2: The 96-bit time format is seconds in [95:48], nanoseconds in [47:16] and fractional nanoseconds in [15:0]. The exit time is entry + FIX_LAT + extra latency. Nanoseconds carry into seconds at 10^9, and fractions carry into nanoseconds at 2^16.
- R3: The extra latency register is 48 bits wide, nanoseconds in [47:16] and fraction in [15:0]. It is zero after reset. It is written from lat_wdata on a cycle with lat_we high. A packet whose start beat is accepted after that write uses the new value.
- R4: When in_two_step is high on the start beat, the frame leaves the block bit-for-bit unchanged, whatever the offset, action and checksum controls are.
- R5: In two-step operation, st2_valid is high for exactly the cycle in which the packet's start beat is on the output, and st2_tod then carries the exit time. st2_valid is never high for a one-step packet.
- R6: In one-step operation, in_action 2'b01 replaces the 12-byte field with the exit time. The field starts at frame byte in_ts_off, and frame byte k sits in beat k/16, lane k%16. The field is stored most significant byte first.
- R7: In one-step operation, in_action 2'b10 writes back field + exit, in_action 2'b11 writes back exit − field, and 2'b00 leaves the field alone. Nanosecond carries and borrows wrap at 10^9, and seconds wrap modulo 2^48.
- R8: In one-step operation, in_zero_csum high clears the two bytes at frame byte in_csum_off. In two-step operation those bytes are never touched.
- R9: A timestamp field or checksum that straddles two beats is rewritten correctly in both beats.
- R10: If a field that must be edited does not lie wholly inside the frame, that field is left unchanged and out_err is high on the output end beat. This applies to the timestamp when the action is not 2'b00, and to the checksum when the clear flag is set. Otherwise out_err stays low.
- R11: All per-packet controls and the entry time are sampled only on the start beat. Their values on later beats of the packet have no effect.
- R12: During and right after reset, out_valid, out_err and st2_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 8*BYTES | Beat data, lane 0 in the low byte |
| in_two_step | input | 1 | Two-step operation for this packet |
| in_ts_off | input | OFFW | Byte position of the timestamp field |
| in_action | input | 2 | One-step action: 00 none, 01 overwrite, 10 add, 11 subtract |
| in_zero_csum | input | 1 | Clear the TCP checksum (one-step only) |
| in_csum_off | input | OFFW | Byte position of the TCP checksum |
| in_tod | input | 96 | Entry time of day |
| lat_we | input | 1 | Extra latency register write strobe |
| lat_wdata | input | 48 | Extra latency write value |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output first beat |
| out_eop | output | 1 | Output last beat |
| out_data | output | 8*BYTES | Output beat data |
| out_err | output | 1 | Field truncated, with the end beat |
| st2_valid | output | 1 | Two-step exit time valid |
| st2_tod | output | 96 | Two-step exit time |

## Verification
Two-step frames carry deliberately non-zero action and checksum controls. This separates a true pass-through from a path that merely happens to leave bytes alone, and it pins the side-bus strobe to the start beat. One-step frames exercise each action in turn:
- an aligned overwrite;
- an add whose nanoseconds carry into seconds;
- a subtract that borrows;
- an add that wraps the seconds.

Field and checksum offsets that cross a beat edge test the held-back beat. Truncated frames, single-beat frames and back-to-back packets whose controls change on non-start beats show whether edits, errors and sampling stay tied to the right packet.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

  typedef struct packed {
    logic [47:0] sec;
    logic [31:0] ns;
    logic [15:0] frac;
  } tod_t;

  typedef struct packed {
    logic [31:0] ns;
    logic [15:0] frac;
  } lat_t;

  localparam logic [32:0] NS_WRAP = 33'd1_000_000_000;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_OVWR = 2'b01,
    ACT_ADD  = 2'b10,
    ACT_SUB  = 2'b11
  } act_e;

  function automatic tod_t tod_add(tod_t a, tod_t b);
    tod_t        r;
    logic [16:0] f;
    logic [32:0] n;
    logic        c;
    f = {1'b0, a.frac} + {1'b0, b.frac};
    n = {1'b0, a.ns} + {1'b0, b.ns} + {32'd0, f[16]};
    c = (n >= NS_WRAP);
    r.frac = f[15:0];
    r.ns   = c ? 32'(n - NS_WRAP) : n[31:0];
    r.sec  = a.sec + b.sec + {47'd0, c};
    return r;
  endfunction

  function automatic tod_t tod_sub(tod_t a, tod_t b);
    tod_t        r;
    logic [16:0] f;
    logic [32:0] n;
    logic        bw;
    f  = {1'b0, a.frac} - {1'b0, b.frac};
    n  = {1'b0, a.ns} - {1'b0, b.ns} - {32'd0, f[16]};
    bw = n[32];
    r.frac = f[15:0];
    r.ns   = bw ? 32'(n + NS_WRAP) : n[31:0];
    r.sec  = a.sec - b.sec - {47'd0, bw};
    return r;
  endfunction

  function automatic tod_t lat_to_tod(lat_t l);
    tod_t r;
    r.sec  = '0;
    r.ns   = l.ns;
    r.frac = l.frac;
    return r;
  endfunction

endpackage

// File: rtl/ptp_exit_calc.sv
module ptp_exit_calc
  import ptp_ts_pkg::*;
#(
  parameter logic [47:0] FIX_LAT = {32'd180, 16'h4000}
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  tod_t entry,
  input  lat_t extra,
  output tod_t exit_q
);

  tod_t base;
  tod_t total;

  always_comb begin
    base  = tod_add(entry, lat_to_tod(lat_t'(FIX_LAT)));
    total = tod_add(base, lat_to_tod(extra));
  end

  always_ff @(posedge clk) begin
    if (rst)       exit_q <= '0;
    else if (load) exit_q <= total;
  end

  // R2: a freshly loaded exit time is normalised
  p_exit_ns_range_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> ({1'b0, exit_q.ns} < NS_WRAP));

endmodule

// File: rtl/ptp_win_patch.sv
module ptp_win_patch
  import ptp_ts_pkg::*;
#(
  parameter int BYTES = 16,
  parameter int FB    = 12,
  localparam int LB   = $clog2(BYTES),
  localparam int WW   = 16 * BYTES
) (
  input  logic [WW-1:0] win_i,
  input  logic          ts_en,
  input  logic [LB-1:0] ts_lane,
  input  logic [1:0]    act,
  input  tod_t          exit_ts,
  input  logic          cs_en,
  input  logic [LB-1:0] cs_lane,
  output logic [WW-1:0] win_o
);

  tod_t fld;
  tod_t upd;
  int   idx;

  always_comb begin
    win_o = win_i;
    fld   = '0;
    upd   = '0;
    idx   = 0;
    if (ts_en) begin
      for (int i = 0; i < FB; i++) begin
        idx = int'(ts_lane) + i;
        fld[8*(FB-1-i) +: 8] = win_i[8*idx +: 8];
      end
      case (act_e'(act))
        ACT_OVWR: upd = exit_ts;
        ACT_ADD:  upd = tod_add(fld, exit_ts);
        ACT_SUB:  upd = tod_sub(exit_ts, fld);
        default:  upd = fld;
      endcase
      for (int i = 0; i < FB; i++) begin
        idx = int'(ts_lane) + i;
        win_o[8*idx +: 8] = upd[8*(FB-1-i) +: 8];
      end
    end
    if (cs_en) begin
      idx = int'(cs_lane);
      win_o[8*idx +: 8]     = 8'h00;
      win_o[8*(idx+1) +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/ptp_tx_stamper.sv
module ptp_tx_stamper
  import ptp_ts_pkg::*;
#(
  parameter int          BYTES   = 16,
  parameter int          OFFW    = 16,
  parameter logic [47:0] FIX_LAT = {32'd180, 16'h4000},
  localparam int DW   = 8 * BYTES,
  localparam int LB   = $clog2(BYTES),
  localparam int CNTW = OFFW - LB + 1,
  localparam int FB   = 12,
  localparam int CB   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic            in_eop,
  input  logic [DW-1:0]   in_data,
  input  logic            in_two_step,
  input  logic [OFFW-1:0] in_ts_off,
  input  logic [1:0]      in_action,
  input  logic            in_zero_csum,
  input  logic [OFFW-1:0] in_csum_off,
  input  logic [95:0]     in_tod,
  input  logic            lat_we,
  input  logic [47:0]     lat_wdata,
  output logic            out_valid,
  output logic            out_sop,
  output logic            out_eop,
  output logic [DW-1:0]   out_data,
  output logic            out_err,
  output logic            st2_valid,
  output logic [95:0]     st2_tod
);

  // held-back beat (s1) and the controls of the packet it belongs to
  logic            s1_v, s1_sop, s1_eop;
  logic [DW-1:0]   s1_data;
  logic [CNTW-1:0] cnt;
  logic            c_two, c_zero;
  logic [1:0]      c_act;
  logic [OFFW-1:0] c_tsoff, c_csoff;
  logic            done_ts, done_cs;
  logic            out_two;
  logic [1:0]      warm;
  lat_t            extra_q;
  tod_t            exit_q;
  logic            start;

  assign start = in_valid & in_sop;

  always_ff @(posedge clk) begin
    if (rst)         extra_q <= '0;
    else if (lat_we) extra_q <= lat_t'(lat_wdata);
  end

  ptp_exit_calc #(.FIX_LAT(FIX_LAT)) i_exit (
    .clk(clk), .rst(rst), .load(start), .entry(tod_t'(in_tod)),
    .extra(extra_q), .exit_q(exit_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      c_two <= 1'b0; c_zero <= 1'b0; c_act <= 2'b00;
      c_tsoff <= '0; c_csoff <= '0;
    end else if (start) begin
      c_two <= in_two_step; c_zero <= in_zero_csum; c_act <= in_action;
      c_tsoff <= in_ts_off; c_csoff <= in_csum_off;
    end
  end

  // field location relative to the held-back beat
  logic need_ts, need_cs, hit_ts, hit_cs, ts_fits, cs_fits;
  logic [LB-1:0] ts_lane, cs_lane;

  assign need_ts = !c_two && (c_act != 2'b00);
  assign need_cs = !c_two && c_zero;
  assign ts_lane = c_tsoff[LB-1:0];
  assign cs_lane = c_csoff[LB-1:0];
  assign ts_fits = (int'(ts_lane) + FB) <= BYTES;
  assign cs_fits = (int'(cs_lane) + CB) <= BYTES;
  assign hit_ts  = s1_v && need_ts && (cnt == {1'b0, c_tsoff[OFFW-1:LB]})
                   && (ts_fits || !s1_eop);
  assign hit_cs  = s1_v && need_cs && (cnt == {1'b0, c_csoff[OFFW-1:LB]})
                   && (cs_fits || !s1_eop);

  logic [2*DW-1:0] win_p;

  ptp_win_patch #(.BYTES(BYTES), .FB(FB)) i_patch (
    .win_i({in_data, s1_data}), .ts_en(hit_ts), .ts_lane(ts_lane),
    .act(c_act), .exit_ts(exit_q), .cs_en(hit_cs), .cs_lane(cs_lane),
    .win_o(win_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_sop <= 1'b0; s1_eop <= 1'b0; s1_data <= '0;
      cnt <= '0; done_ts <= 1'b0; done_cs <= 1'b0;
    end else begin
      s1_v    <= in_valid;
      s1_sop  <= start;
      s1_eop  <= in_valid & in_eop;
      s1_data <= win_p[2*DW-1:DW];
      if (start)                          cnt <= '0;
      else if (in_valid && (cnt != '1))   cnt <= cnt + 1'b1;
      if (start) begin
        done_ts <= 1'b0; done_cs <= 1'b0;
      end else begin
        if (hit_ts) done_ts <= 1'b1;
        if (hit_cs) done_cs <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0; out_sop <= 1'b0; out_eop <= 1'b0;
      out_data <= '0; out_err <= 1'b0; out_two <= 1'b0;
      st2_valid <= 1'b0; st2_tod <= '0; warm <= 2'd0;
    end else begin
      out_valid <= s1_v;
      out_sop   <= s1_v & s1_sop;
      out_eop   <= s1_v & s1_eop;
      out_data  <= win_p[DW-1:0];
      out_two   <= c_two;
      out_err   <= s1_v & s1_eop &
                   ((need_ts & !(done_ts | hit_ts)) | (need_cs & !(done_cs | hit_cs)));
      st2_valid <= s1_v & s1_sop & c_two;
      if (s1_v && s1_sop && c_two) st2_tod <= exit_q;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // R1: fixed two-cycle delay of the markers
  p_delay_r1: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 2)) &&
                       (out_sop == $past(in_valid & in_sop, 2)));

  // R4: two-step beats leave exactly as they came in
  p_pass_two_step_r4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid && out_two) |-> (out_data == $past(in_data, 2)));

  // R5: side-bus strobe only with an output start beat
  p_strobe_on_sop_r5: assert property (@(posedge clk) disable iff (rst)
    st2_valid |-> (out_valid && out_sop));

  // R10: error flag only on an output end beat
  p_err_on_eop_r10: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && out_eop));

endmodule

// File: tb/test_ptp_tx_stamper.sv
module test_ptp_tx_stamper;

  localparam logic [47:0] FIX = {32'd180, 16'h4000};
  localparam longint UNIT = 64'd1000000000 * 64'd65536;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [127:0] in_data = '0;
  logic in_two_step = 0, in_zero_csum = 0;
  logic [15:0] in_ts_off = '0, in_csum_off = '0;
  logic [1:0] in_action = '0;
  logic [95:0] in_tod = '0;
  logic lat_we = 0;
  logic [47:0] lat_wdata = '0;
  logic out_valid, out_sop, out_eop, out_err, st2_valid;
  logic [127:0] out_data;
  logic [95:0] st2_tod;

  always #2.5 clk = ~clk;

  ptp_tx_stamper #(.BYTES(16), .OFFW(16), .FIX_LAT(FIX)) i_ptp_tx_stamper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_two_step(in_two_step), .in_ts_off(in_ts_off),
    .in_action(in_action), .in_zero_csum(in_zero_csum), .in_csum_off(in_csum_off),
    .in_tod(in_tod), .lat_we(lat_we), .lat_wdata(lat_wdata),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .out_err(out_err), .st2_valid(st2_valid), .st2_tod(st2_tod)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit run = 0, over = 0;
  logic [47:0] extra = '0;

  int           qc[$];
  logic [127:0] qd[$];
  logic [3:0]   qf[$];
  logic [95:0]  qt[$];
  string        qr[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [95:0] m_add(logic [95:0] a, logic [95:0] b);
    longint s;
    logic [47:0] sec;
    s   = longint'(a[47:16]) * 65536 + longint'(a[15:0]) + longint'(b[47:16]) * 65536 + longint'(b[15:0]);
    sec = a[95:48] + b[95:48];
    if (s >= UNIT) begin s = s - UNIT; sec = sec + 48'd1; end
    return {sec, 32'(s / 65536), 16'(s % 65536)};
  endfunction

  function automatic logic [95:0] m_sub(logic [95:0] a, logic [95:0] b);
    longint s;
    logic [47:0] sec;
    s   = longint'(a[47:16]) * 65536 + longint'(a[15:0]) - longint'(b[47:16]) * 65536 - longint'(b[15:0]);
    sec = a[95:48] - b[95:48];
    if (s < 0) begin s = s + UNIT; sec = sec - 48'd1; end
    return {sec, 32'(s / 65536), 16'(s % 65536)};
  endfunction

  // output comparator: every cycle either an expected beat or idle
  always @(negedge clk) begin
    if (run) begin
      if (qc.size() > 0 && qc[0] == cyc) begin
        chk(out_valid && {out_sop, out_eop, out_err} == qf[0][3:1],
            {qr[0], " markers"}, {125'd0, out_sop, out_eop, out_err}, {125'd0, qf[0][3:1]});
        chk(out_data == qd[0], {qr[0], " data"}, out_data, qd[0]);
        chk(st2_valid == qf[0][0], "R5 strobe", {127'd0, st2_valid}, {127'd0, qf[0][0]});
        if (qf[0][0]) chk(st2_tod == qt[0], "R5/R2 exit time", {32'd0, st2_tod}, {32'd0, qt[0]});
        void'(qc.pop_front()); void'(qd.pop_front()); void'(qf.pop_front());
        void'(qt.pop_front()); void'(qr.pop_front());
      end else begin
        chk(!out_valid && !st2_valid && !out_err, "R1 idle",
            {125'd0, out_valid, st2_valid, out_err}, 128'd0);
      end
    end
  end

  task automatic send(input int nb, input bit two, input logic [1:0] act, input bit zero,
                      input int tsoff, input int csoff, input logic [95:0] tod,
                      input logic [95:0] fld, input string req);
    logic [7:0] fr [0:127];
    logic [7:0] ef [0:127];
    logic [95:0] ex, nv;
    bit ts_ok, cs_ok, err;
    int len;
    len = nb * 16;
    for (int k = 0; k < 128; k++) fr[k] = 8'($urandom);
    ts_ok = (tsoff + 12 <= len);
    cs_ok = (csoff + 2 <= len);
    if (ts_ok) for (int i = 0; i < 12; i++) fr[tsoff+i] = fld[8*(11-i) +: 8];
    for (int k = 0; k < 128; k++) ef[k] = fr[k];
    ex  = m_add(m_add(tod, {48'd0, FIX}), {48'd0, extra});
    err = 0;
    if (!two) begin
      if (act != 2'b00) begin
        if (ts_ok) begin
          nv = (act == 2'b01) ? ex : (act == 2'b10) ? m_add(fld, ex) : m_sub(ex, fld);
          for (int i = 0; i < 12; i++) ef[tsoff+i] = nv[8*(11-i) +: 8];
        end else err = 1;
      end
      if (zero) begin
        if (cs_ok) begin ef[csoff] = 8'h00; ef[csoff+1] = 8'h00; end
        else err = 1;
      end
    end
    for (int b = 0; b < nb; b++) begin
      logic [127:0] d, e;
      @(negedge clk);
      for (int j = 0; j < 16; j++) begin
        d[8*j +: 8] = fr[b*16+j];
        e[8*j +: 8] = ef[b*16+j];
      end
      in_valid = 1; in_sop = (b == 0); in_eop = (b == nb - 1); in_data = d;
      if (b == 0) begin
        in_two_step = two; in_action = act; in_zero_csum = zero;
        in_ts_off = 16'(tsoff); in_csum_off = 16'(csoff); in_tod = tod;
      end else begin
        // R11: junk controls on non-start beats must have no effect
        in_two_step = 1'($urandom); in_action = 2'($urandom); in_zero_csum = 1'($urandom);
        in_ts_off = 16'($urandom); in_csum_off = 16'($urandom);
        in_tod = {$urandom, $urandom, $urandom};
      end
      qc.push_back(cyc + 2); qd.push_back(e);
      qf.push_back({b == 0, b == nb - 1, err && (b == nb - 1), two && (b == 0)});
      qt.push_back(ex); qr.push_back(req);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
  endtask

  task automatic write_lat(input logic [47:0] v);
    @(negedge clk);
    lat_we = 1; lat_wdata = v;
    @(negedge clk);
    lat_we = 0;
    extra = v;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    over = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs quiet in reset
    chk(!out_valid && !out_err && !st2_valid, "R12 in reset",
        {125'd0, out_valid, out_err, st2_valid}, 128'd0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(!out_valid && !out_err && !st2_valid, "R12 after reset",
        {125'd0, out_valid, out_err, st2_valid}, 128'd0);
    run = 1;

    // R4 R5: two-step with live-looking controls, first packet uses zero extra latency (R3)
    send(3, 1, 2'b01, 1, 20, 30, {48'h1234, 32'd999_999_900, 16'hF000},
         {48'h7, 32'd5, 16'd0}, "R4/R3");
    idle(2);
    // R6: overwrite inside one beat, exit time carries into seconds (R2)
    send(4, 0, 2'b01, 0, 34, 0, {48'h1234, 32'd999_999_900, 16'hF000},
         {48'h1, 32'd1, 16'd1}, "R6/R2");
    // R7 R9: add straddling beats 0 and 1, with nanosecond carry
    send(3, 0, 2'b10, 0, 10, 0, {48'h20, 32'd400_000_000, 16'h0100},
         {48'h10, 32'd999_000_000, 16'h9000}, "R7/R9 add");
    idle(1);
    // R7: subtract with borrow
    send(4, 0, 2'b11, 0, 40, 0, {48'h50, 32'd100, 16'h0000},
         {48'h1, 32'd999_999_999, 16'hFFFF}, "R7 sub");
    // R8 R9: action none, checksum straddling beat edge
    send(2, 0, 2'b00, 1, 15, 0, {48'h3, 32'd7, 16'd7},
         {48'h0, 32'd0, 16'd0}, "R8/R9 csum");
    idle(3);
    // R3: new extra latency
    write_lat({32'd999_999_000, 16'hC000});
    send(2, 0, 2'b01, 1, 0, 12, {48'h9, 32'd500, 16'h5000},
         {48'h0, 32'd0, 16'd0}, "R3 latency");
    // R10: timestamp straddles past end
    send(2, 0, 2'b01, 0, 26, 0, {48'h9, 32'd1, 16'd1},
         {48'h0, 32'd0, 16'd0}, "R10 trunc ts");
    // R10: field far beyond frame
    send(1, 0, 2'b10, 0, 100, 0, {48'h9, 32'd1, 16'd1},
         {48'h0, 32'd0, 16'd0}, "R10 beyond");
    // R10: checksum truncated on a single-beat frame
    send(1, 0, 2'b00, 1, 0, 15, {48'h9, 32'd1, 16'd1},
         {48'h0, 32'd0, 16'd0}, "R10 trunc csum");
    // R10: no edits requested, no error even with offsets outside
    send(1, 0, 2'b00, 0, 200, 200, {48'h9, 32'd1, 16'd1},
         {48'h0, 32'd0, 16'd0}, "R10 no err");
    // R8: two-step with clear flag leaves checksum alone
    send(2, 1, 2'b11, 1, 4, 8, {48'h2, 32'd2, 16'd2},
         {48'h0, 32'd0, 16'd0}, "R8/R4 two-step csum");
    // R6 R11: single-beat overwrite back to back
    send(1, 0, 2'b01, 0, 4, 0, {48'hA, 32'd10, 16'd10},
         {48'h0, 32'd0, 16'd0}, "R6/R11 single");
    // R7: seconds wrap on add
    send(3, 0, 2'b10, 1, 18, 40, {48'hFFFF_FFFF_FFFF, 32'd900_000_000, 16'd0},
         {48'h5, 32'd200_000_000, 16'd0}, "R7 wrap");
    idle(6);
    run = 0;
    chk(qc.size() == 0, "R1 drained", 128'(qc.size()), 128'd0);
    if (!over) finish_run();
  end

endmodule